// File: doc/BRIEF.md
# Return-burst payload assembler

This block builds the payload that a remote line terminal sends back to its master station in each return burst. An 8-bit voice word arrives serially on a data pin. A rising edge on an enable strobe arms the capture, and the word is then shifted in MSB first on the next eight falling edges of an external data clock. Only a word with all eight bits captured replaces the stored word. A word cut short by a new arming edge is dropped.

Two signaling bits are latched alongside the voice word. While the link to the master is up, they latch on the rising edge of the transmit-enable pulse. While the link is down and the terminal is powered up, an internal timer latches them instead. A loopback control, active low, replaces the captured voice word with the most recently demodulated word from the master, so the link can be tested end to end. The transmitter reads a parallel 10-bit payload that is updated by a load strobe.

All inputs are sampled on the system clock `clk_i`. Edges of the enable strobe, data clock and transmit-enable pulse are found by comparing each input with its value registered one cycle earlier.

Top module: `burst_payload_asm`

## Requirements
- R1: After reset `payload_o` is 0, the stored voice word is 0 and both latched signaling bits are 0. A load before any capture or latch gives 0.
- R2: A rising edge of `rx_en_i` arms capture. `rx_sd_i` is sampled on each of the next eight falling edges of `dclk_i`, and the first bit becomes the voice MSB. A `dclk_i` falling edge seen in the same clock cycle as the arming edge is not counted.
- R3: The eighth sampled bit commits the word and disarms capture. Further `dclk_i` falling edges leave the stored word unchanged until capture is armed again.
- R4: A rising edge of `rx_en_i` before eight bits are sampled discards the partial word and restarts the count at zero. The previously stored word is kept.
- R5: With no new capture, each later load presents the same stored voice word again.
- R6: While `link_up_i` is 1, `sig1_i` and `sig2_i` are latched only on a rising edge of `te_i`.
- R7: While `link_up_i` is 0 and `pwr_up_i` is 1, the signaling bits are latched once every `TICK_CYC` clock cycles by an internal timer. The timer starts from zero when the link drops.
- R8: While `link_up_i` and `pwr_up_i` are both 0, the latched signaling bits do not change.
- R9: When `lb_ni` is 0 and `pwr_up_i` is 1, a load takes the voice field from `demod_word_i` and the signaling bits pass through as usual. When `lb_ni` is 0 and `pwr_up_i` is 0, the stored captured word is used.
- R10: A clock edge with `load_i` at 1 sets `payload_o` to {voice[7:0], sig1, sig2}, so voice occupies bits 9:2 with its MSB at bit 9, sig1 is bit 1 and sig2 is bit 0. The new value is visible after that edge, and `payload_o` holds its value while `load_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Capture-arming strobe (rising edge) |
| dclk_i | input | 1 | External data clock (falling edges sample) |
| rx_sd_i | input | 1 | Serial voice data |
| sig1_i | input | 1 | Signaling bit 1 |
| sig2_i | input | 1 | Signaling bit 2 |
| te_i | input | 1 | Transmit-enable pulse (rising edge latches signaling) |
| link_up_i | input | 1 | Master bursts are being received |
| pwr_up_i | input | 1 | Terminal powered up |
| lb_ni | input | 1 | Loopback request, active low |
| demod_word_i | input | 8 | Last demodulated voice word |
| load_i | input | 1 | Payload load strobe |
| payload_o | output | 10 | Burst payload {voice, sig1, sig2} |

## Verification
Every input edge is seen through one register stage, so a captured bit, a latched signaling pair or a timer tick takes effect on the same clock edge where the input change is first sampled. The payload follows one edge after `load_i` is seen. The bench drives every input on the falling edge of `clk_i`. It then runs each load as a one-cycle pulse and reads `payload_o` on the next falling edge, half a cycle after the edge that registered it. For the timer case, the bench loads once well before `TICK_CYC` cycles have passed and once well after, so the check does not depend on the exact tick cycle.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int unsigned SIG_W = 2;

  typedef enum logic [1:0] {
    SIG_HOLD = 2'd0,
    SIG_TE   = 2'd1,
    SIG_TICK = 2'd2
  } sig_src_e;
endpackage

// File: rtl/pl_edge.sv
module pl_edge #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= in_i[g];
    end
    assign rise_o[g] = in_i[g] & ~prev_q;
    assign fall_o[g] = ~in_i[g] & prev_q;
  end
endmodule

// File: rtl/pl_ser_capture.sv
module pl_ser_capture #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            fall_i,
  input  logic            sd_i,
  output logic            armed_o,
  output logic [BITS-1:0] word_o
);
  localparam int unsigned CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic            armed_q;
  logic [CW-1:0]   cnt_q;
  logic [BITS-1:0] sh_q, word_q, sh_nxt;

  assign sh_nxt = {sh_q[BITS-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
    end else if (arm_i) begin
      // arming edge never samples; any partial word is dropped
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && fall_i) begin
      sh_q <= sh_nxt;
      if (cnt_q == LAST) begin
        word_q  <= sh_nxt;
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign word_o  = word_q;
endmodule

// File: rtl/pl_sig_latch.sv
module pl_sig_latch
  import pl_pkg::*;
#(
  parameter int unsigned TICK_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             te_rise_i,
  input  logic             link_up_i,
  input  logic             pwr_up_i,
  output logic [SIG_W-1:0] sig_o
);
  localparam int unsigned TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICK_CYC - 1);

  logic [TW-1:0]    tmr_q;
  logic             tick;
  logic             free_run;
  sig_src_e         src;
  logic [SIG_W-1:0] sig_q;

  assign free_run = ~link_up_i & pwr_up_i;
  assign tick     = free_run && (tmr_q == TLAST);

  always_comb begin
    if (link_up_i && te_rise_i) src = SIG_TE;
    else if (tick)              src = SIG_TICK;
    else                        src = SIG_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (!free_run || tick) tmr_q <= '0;
    else                        tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sig_q <= '0;
    else if (src != SIG_HOLD)  sig_q <= sig_i;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/burst_payload_asm.sv
module burst_payload_asm
  import pl_pkg::*;
#(
  parameter int unsigned VOICE_W  = 8,
  parameter int unsigned TICK_CYC = 16,
  localparam int unsigned PAY_W   = VOICE_W + SIG_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_en_i,
  input  logic               dclk_i,
  input  logic               rx_sd_i,
  input  logic               sig1_i,
  input  logic               sig2_i,
  input  logic               te_i,
  input  logic               link_up_i,
  input  logic               pwr_up_i,
  input  logic               lb_ni,
  input  logic [VOICE_W-1:0] demod_word_i,
  input  logic               load_i,
  output logic [PAY_W-1:0]   payload_o
);
  logic [2:0]         rise, fall;
  logic               te_rise;
  logic               armed;
  logic [VOICE_W-1:0] cap_word, voice_sel;
  logic [SIG_W-1:0]   sig_q;
  logic [PAY_W-1:0]   payload_q;

  // bit 0: enable strobe, bit 1: data clock, bit 2: transmit enable
  pl_edge #(.W(3)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({te_i, dclk_i, rx_en_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign te_rise = rise[2];

  pl_ser_capture #(.BITS(VOICE_W)) i_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (rise[0]),
    .fall_i  (fall[1]),
    .sd_i    (rx_sd_i),
    .armed_o (armed),
    .word_o  (cap_word)
  );

  pl_sig_latch #(.TICK_CYC(TICK_CYC)) i_sig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sig_i     ({sig1_i, sig2_i}),
    .te_rise_i (te_rise),
    .link_up_i (link_up_i),
    .pwr_up_i  (pwr_up_i),
    .sig_o     (sig_q)
  );

  assign voice_sel = (!lb_ni && pwr_up_i) ? demod_word_i : cap_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     payload_q <= '0;
    else if (load_i) payload_q <= {voice_sel, sig_q};
  end

  assign payload_o = payload_q;
endmodule

// File: rtl/pl_chk.sv
module pl_chk #(
  parameter int unsigned VOICE_W = 8,
  localparam int unsigned PAY_W  = VOICE_W + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               lb_ni,
  input logic               pwr_up_i,
  input logic               link_up_i,
  input logic               te_rise_i,
  input logic               armed_i,
  input logic [VOICE_W-1:0] word_i,
  input logic [1:0]         sig_i,
  input logic [VOICE_W-1:0] demod_i,
  input logic [PAY_W-1:0]   payload_o
);
  // R10
  payload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(payload_o));

  // R10
  payload_sig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> payload_o[1:0] == $past(sig_i));

  // R9
  loopback_voice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !lb_ni && pwr_up_i) |=> payload_o[PAY_W-1:2] == $past(demod_i));

  // R5
  captured_voice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (lb_ni || !pwr_up_i)) |=> payload_o[PAY_W-1:2] == $past(word_i));

  // R3
  word_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable(word_i));

  // R6
  sig_te_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_up_i && !te_rise_i) |=> $stable(sig_i));

  // R8
  sig_pwr_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_up_i && !pwr_up_i) |=> $stable(sig_i));
endmodule

bind burst_payload_asm pl_chk #(.VOICE_W(VOICE_W)) i_pl_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .lb_ni     (lb_ni),
  .pwr_up_i  (pwr_up_i),
  .link_up_i (link_up_i),
  .te_rise_i (te_rise),
  .armed_i   (armed),
  .word_i    (cap_word),
  .sig_i     (sig_q),
  .demod_i   (demod_word_i),
  .payload_o (payload_o)
);

// File: tb/test_burst_payload_asm.sv
module test_burst_payload_asm;
  localparam int TICK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 0, dclk = 0, sd = 0, s1 = 0, s2 = 0, te = 0;
  logic       link_up = 1, pwr = 1, lb_n = 1, load = 0;
  logic [7:0] demod = 8'h00;
  logic [9:0] pay;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_payload_asm #(.VOICE_W(8), .TICK_CYC(TICK)) i_burst_payload_asm (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_en_i      (rx_en),
    .dclk_i       (dclk),
    .rx_sd_i      (sd),
    .sig1_i       (s1),
    .sig2_i       (s2),
    .te_i         (te),
    .link_up_i    (link_up),
    .pwr_up_i     (pwr),
    .lb_ni        (lb_n),
    .demod_word_i (demod),
    .load_i       (load),
    .payload_o    (pay)
  );

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: payload %h, expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic do_load(input string req, input logic [9:0] exp);
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    check(req, pay, exp);
  endtask

  // arm, then send nbits MSB first; leaves dclk high and rx_en low
  task automatic send(input logic [7:0] w, input int nbits, input bit fall_at_arm);
    if (fall_at_arm) begin
      @(negedge clk) begin dclk = 1'b1; rx_en = 1'b0; end
      @(negedge clk) begin rx_en = 1'b1; dclk = 1'b0; sd = 1'b1; end
      @(negedge clk) dclk = 1'b1;
    end else begin
      @(negedge clk) begin rx_en = 1'b1; dclk = 1'b1; end
    end
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk) begin dclk = 1'b0; sd = w[7-i]; end
      @(negedge clk) dclk = 1'b1;
    end
    @(negedge clk) rx_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", pay, 10'h000);
    do_load("R1 empty load", 10'h000);
  endtask

  task automatic t_capture();
    send(8'hA5, 8, 1'b0);
    do_load("R2 capture A5", {8'hA5, 2'b00});
    send(8'h3C, 8, 1'b1);
    do_load("R2 arm-cycle edge ignored", {8'h3C, 2'b00});
    check("R10 hold without load", pay, {8'h3C, 2'b00});
  endtask

  task automatic t_extra_edges();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) begin dclk = 1'b0; sd = 1'b1; end
      @(negedge clk) dclk = 1'b1;
    end
    do_load("R3 extra edges ignored", {8'h3C, 2'b00});
  endtask

  task automatic t_partial();
    send(8'hFF, 5, 1'b0);
    do_load("R4 partial discarded", {8'h3C, 2'b00});
    send(8'hFF, 3, 1'b0);
    send(8'h81, 8, 1'b0);
    do_load("R4 restart after re-arm", {8'h81, 2'b00});
    do_load("R5 word reused", {8'h81, 2'b00});
  endtask

  task automatic t_sig_te();
    @(negedge clk) begin s1 = 1'b1; s2 = 1'b0; end
    repeat (3) @(negedge clk);
    do_load("R6 no te no latch", {8'h81, 2'b00});
    @(negedge clk) te = 1'b1;
    @(negedge clk) te = 1'b0;
    do_load("R6 te latch", {8'h81, 2'b10});
  endtask

  task automatic t_sig_tick();
    @(negedge clk) begin link_up = 1'b0; s1 = 1'b0; s2 = 1'b1; end
    do_load("R7 before tick", {8'h81, 2'b10});
    repeat (TICK) @(negedge clk);
    do_load("R7 after tick", {8'h81, 2'b01});
  endtask

  task automatic t_sig_pwrdn();
    @(negedge clk) begin pwr = 1'b0; s1 = 1'b1; s2 = 1'b1; end
    repeat (3 * TICK) @(negedge clk);
    do_load("R8 powered down hold", {8'h81, 2'b01});
  endtask

  task automatic t_loopback();
    @(negedge clk) begin pwr = 1'b1; link_up = 1'b1; lb_n = 1'b0; demod = 8'hC3; end
    do_load("R9 loopback voice", {8'hC3, 2'b01});
    @(negedge clk) pwr = 1'b0;
    do_load("R9 loopback needs power", {8'h81, 2'b01});
    @(negedge clk) begin pwr = 1'b1; lb_n = 1'b1; end
    do_load("R9 loopback released", {8'h81, 2'b01});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_extra_edges();
    t_partial();
    t_sig_te();
    t_sig_tick();
    t_sig_pwrdn();
    t_loopback();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end
endmodule